// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell

This block provides doorbell mailboxes for a cluster of four cores. Each core owns four 32-bit mailboxes. Any core may post event bits into another core's mailbox by writing a word to that mailbox's set window. The owning core reads the mailbox and acknowledges the bits it has handled by writing them to the mailbox's clear window. Because setting and clearing use separate addresses, and because each mailbox has its own pair of windows, cores can post and acknowledge at the same time without a read-modify-write race.

Each core has a mailbox configuration register. It chooses which of that core's non-empty mailboxes drive the core's IRQ request and which drive its FIQ request. The block also exports a raw per-mailbox pending vector for an external interrupt router. Several requesters reach the block through `NPORT` independent access ports, so more than one access can land in the same cycle.

Every access port is a valid/ready request channel with a registered read response. `req_ready` is always high, so the block never applies back-pressure, and each request is accepted in the cycle its valid is high. A read answers with `rsp_valid` one cycle after acceptance. The response has no ready, so the requester must take it in that cycle. Writes produce no response.

Top module: `mbx_doorbell`

## Requirements
- R1: A write of word W to address 0x80 + 16*c + 4*m sets every bit of mailbox m of core c that is one in W and leaves its other bits unchanged.
- R2: A write of word W to address 0xC0 + 16*c + 4*m clears every bit of mailbox m of core c that is one in W and leaves its other bits unchanged.
- R3: A read of a set or clear window returns the current mailbox contents, as held before any write accepted in the same cycle, and does not change them. `rsp_valid` goes high exactly in the cycle after an accepted read and stays low after writes. `req_ready` is always high.
- R4: The configuration register of core c is at 0x50 + 4*c. Bit m enables mailbox m onto the IRQ request and bit m+4 enables it onto the FIQ request. A read returns bits 7:0 as written, with all higher bits zero.
- R5: `mbox_pend[4*c+m]` is high exactly when mailbox m of core c is non-zero. The pending word of core c, read at 0x60 + 4*c, shows the same four flags at bits 7:4, with all other bits zero.
- R6: A mailbox that still holds any set bit after a partial clear stays pending. It stops pending only once every bit has been cleared.
- R7: `irq[c]` is the OR over m of (pending m AND configuration bit m). `fiq[c]` is the OR over m of (pending m AND configuration bit m+4).
- R8: When a set and a clear reach the same mailbox in the same cycle, any bit that is one in both words ends up set. Sets to one mailbox from several ports in one cycle combine by OR.
- R9: After reset all mailboxes, configuration registers, `irq`, `fiq`, `mbox_pend` and `rsp_valid` are zero.
- R10: A write to a misaligned or unmapped address changes nothing. A read of one returns zero.
- R11: When several ports write the same configuration register in one cycle, the highest-numbered port's data is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request valid, one per port |
| req_ready | output | NPORT | Request ready, one per port, always high |
| req_write | input | NPORT | 1 = write, 0 = read, one per port |
| req_addr | input | NPORT*AW | Byte address, AW bits per port |
| req_wdata | input | NPORT*DW | Write data, DW bits per port |
| rsp_valid | output | NPORT | Read response valid, one per port |
| rsp_rdata | output | NPORT*DW | Read response data, DW bits per port |
| mbox_pend | output | NCORE*NMBOX | Mailbox non-empty flags, index 4*c+m |
| irq | output | NCORE | Gated IRQ request per core |
| fiq | output | NCORE | Gated FIQ request per core |

## Verification
The bench performs partial acknowledges and checks that pending holds until the last bit is gone. A design that dropped pending on any clear would lose doorbells. It drives a set and a clear from two ports into one mailbox in the same cycle, where a clear-wins design would erase a freshly posted bit. It also drives two sets from two ports into one mailbox, where a design that kept only one port would drop bits. Separate IRQ and FIQ enables on one core catch a swapped enable field. Colliding configuration writes, and misaligned or unmapped writes, catch a wrong winner or a decoder that aliases stray addresses onto a mailbox.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SET,
    ACC_CLR,
    ACC_CFG,
    ACC_PEND
  } acc_kind_e;

  localparam int unsigned CFG_BASE    = 32'h50;
  localparam int unsigned PEND_BASE   = 32'h60;
  localparam int unsigned SET_BASE    = 32'h80;
  localparam int unsigned CLR_BASE    = 32'hC0;
  localparam int unsigned CORE_STRIDE = 16;
  localparam int unsigned SLOT_STRIDE = 4;
  localparam int unsigned PEND_LSB    = 4;
endpackage

// File: rtl/mbx_port.sv
module mbx_port #(
  parameter int NCORE = 4,
  parameter int NMBOX = 4,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [NCORE*NMBOX*DW-1:0] mb_all,
  input  logic [NCORE*2*NMBOX-1:0]  cfg_all,
  input  logic [NCORE*NMBOX-1:0]    nz_all,
  output logic                      req_ready,
  output logic [NCORE*NMBOX-1:0]    set_hit,
  output logic [NCORE*NMBOX-1:0]    clr_hit,
  output logic [NCORE-1:0]          cfg_hit,
  output logic                      rsp_valid,
  output logic [DW-1:0]             rsp_rdata
);
  import mbx_pkg::*;

  localparam int CFGW = 2 * NMBOX;

  acc_kind_e   kind;
  int unsigned core_i;
  int unsigned mbox_i;
  logic [DW-1:0] rd_next;

  assign req_ready = 1'b1;

  // address decode
  always_comb begin
    int unsigned a;
    a      = 32'(req_addr);
    kind   = ACC_NONE;
    core_i = 0;
    mbox_i = 0;
    if (a[1:0] == 2'b00) begin
      if (a >= SET_BASE && a < SET_BASE + CORE_STRIDE * NCORE) begin
        core_i = (a - SET_BASE) / CORE_STRIDE;
        mbox_i = ((a - SET_BASE) % CORE_STRIDE) / SLOT_STRIDE;
        if (mbox_i < NMBOX) kind = ACC_SET;
      end else if (a >= CLR_BASE && a < CLR_BASE + CORE_STRIDE * NCORE) begin
        core_i = (a - CLR_BASE) / CORE_STRIDE;
        mbox_i = ((a - CLR_BASE) % CORE_STRIDE) / SLOT_STRIDE;
        if (mbox_i < NMBOX) kind = ACC_CLR;
      end else if (a >= CFG_BASE && a < CFG_BASE + SLOT_STRIDE * NCORE) begin
        core_i = (a - CFG_BASE) / SLOT_STRIDE;
        kind   = ACC_CFG;
      end else if (a >= PEND_BASE && a < PEND_BASE + SLOT_STRIDE * NCORE) begin
        core_i = (a - PEND_BASE) / SLOT_STRIDE;
        kind   = ACC_PEND;
      end
    end
  end

  // write strobes toward the storage
  always_comb begin
    set_hit = '0;
    clr_hit = '0;
    cfg_hit = '0;
    if (req_valid && req_write) begin
      case (kind)
        ACC_SET: set_hit[core_i*NMBOX + mbox_i] = 1'b1;
        ACC_CLR: clr_hit[core_i*NMBOX + mbox_i] = 1'b1;
        ACC_CFG: cfg_hit[core_i] = 1'b1;
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_next = '0;
    case (kind)
      ACC_SET, ACC_CLR: rd_next = mb_all[(core_i*NMBOX + mbox_i)*DW +: DW];
      ACC_CFG:          rd_next[CFGW-1:0] = cfg_all[core_i*CFGW +: CFGW];
      ACC_PEND:         rd_next[PEND_LSB +: NMBOX] = nz_all[core_i*NMBOX +: NMBOX];
      default:          rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int NMBOX = 4,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NMBOX*DW-1:0] set_w,
  input  logic [NMBOX*DW-1:0] clr_w,
  output logic [NMBOX*DW-1:0] mb,
  output logic [NMBOX-1:0]    nz
);
  for (genvar m = 0; m < NMBOX; m++) begin : g_box
    // clear first, then set, so a bit in both words survives
    always_ff @(posedge clk) begin
      if (!rst_n) mb[m*DW +: DW] <= '0;
      else        mb[m*DW +: DW] <= (mb[m*DW +: DW] & ~clr_w[m*DW +: DW])
                                    | set_w[m*DW +: DW];
    end
    assign nz[m] = |mb[m*DW +: DW];
  end
endmodule

// File: rtl/mbx_gate.sv
module mbx_gate #(
  parameter int NMBOX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2*NMBOX-1:0] wd,
  input  logic [NMBOX-1:0]   nz,
  output logic [2*NMBOX-1:0] cfg,
  output logic               irq,
  output logic               fiq
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= wd;
  end

  assign irq = |(nz & cfg[NMBOX-1:0]);
  assign fiq = |(nz & cfg[2*NMBOX-1:NMBOX]);
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int NCORE = 4,
  parameter int NMBOX = 4,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int NPORT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       req_valid,
  output logic [NPORT-1:0]       req_ready,
  input  logic [NPORT-1:0]       req_write,
  input  logic [NPORT*AW-1:0]    req_addr,
  input  logic [NPORT*DW-1:0]    req_wdata,
  output logic [NPORT-1:0]       rsp_valid,
  output logic [NPORT*DW-1:0]    rsp_rdata,
  output logic [NCORE*NMBOX-1:0] mbox_pend,
  output logic [NCORE-1:0]       irq,
  output logic [NCORE-1:0]       fiq
);
  localparam int NBOX = NCORE * NMBOX;
  localparam int CFGW = 2 * NMBOX;

  logic [NBOX*DW-1:0]       mb_all;
  logic [NBOX-1:0]          nz_all;
  logic [NCORE*CFGW-1:0]    cfg_all;
  logic [NPORT*NBOX-1:0]    set_hit_all;
  logic [NPORT*NBOX-1:0]    clr_hit_all;
  logic [NPORT*NCORE-1:0]   cfg_hit_all;
  logic [NBOX*DW-1:0]       set_word;
  logic [NBOX*DW-1:0]       clr_word;
  logic [NCORE-1:0]         cfg_we;
  logic [NCORE*CFGW-1:0]    cfg_wd;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port #(.NCORE(NCORE), .NMBOX(NMBOX), .DW(DW), .AW(AW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[p]),
      .req_write (req_write[p]),
      .req_addr  (req_addr[p*AW +: AW]),
      .mb_all    (mb_all),
      .cfg_all   (cfg_all),
      .nz_all    (nz_all),
      .req_ready (req_ready[p]),
      .set_hit   (set_hit_all[p*NBOX +: NBOX]),
      .clr_hit   (clr_hit_all[p*NBOX +: NBOX]),
      .cfg_hit   (cfg_hit_all[p*NCORE +: NCORE]),
      .rsp_valid (rsp_valid[p]),
      .rsp_rdata (rsp_rdata[p*DW +: DW])
    );
  end

  // merge all ports: sets and clears OR together, config last port wins
  always_comb begin
    set_word = '0;
    clr_word = '0;
    cfg_we   = '0;
    cfg_wd   = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int i = 0; i < NBOX; i++) begin
        if (set_hit_all[p*NBOX + i]) set_word[i*DW +: DW] |= req_wdata[p*DW +: DW];
        if (clr_hit_all[p*NBOX + i]) clr_word[i*DW +: DW] |= req_wdata[p*DW +: DW];
      end
      for (int c = 0; c < NCORE; c++) begin
        if (cfg_hit_all[p*NCORE + c]) begin
          cfg_we[c]               = 1'b1;
          cfg_wd[c*CFGW +: CFGW]  = req_wdata[p*DW +: CFGW];
        end
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    mbx_bank #(.NMBOX(NMBOX), .DW(DW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_w (set_word[c*NMBOX*DW +: NMBOX*DW]),
      .clr_w (clr_word[c*NMBOX*DW +: NMBOX*DW]),
      .mb    (mb_all[c*NMBOX*DW +: NMBOX*DW]),
      .nz    (nz_all[c*NMBOX +: NMBOX])
    );
    mbx_gate #(.NMBOX(NMBOX)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we[c]),
      .wd    (cfg_wd[c*CFGW +: CFGW]),
      .nz    (nz_all[c*NMBOX +: NMBOX]),
      .cfg   (cfg_all[c*CFGW +: CFGW]),
      .irq   (irq[c]),
      .fiq   (fiq[c])
    );
  end

  assign mbox_pend = nz_all;
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
  parameter int NCORE = 4,
  parameter int NMBOX = 4,
  parameter int DW    = 32,
  parameter int NPORT = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORT-1:0]         req_valid,
  input logic [NPORT-1:0]         req_write,
  input logic [NPORT-1:0]         rsp_valid,
  input logic [NCORE*NMBOX-1:0]   mbox_pend,
  input logic [NCORE-1:0]         irq,
  input logic [NCORE-1:0]         fiq,
  input logic [NCORE*NMBOX*DW-1:0] set_word,
  input logic [NCORE*NMBOX*DW-1:0] clr_word
);
  for (genvar c = 0; c < NCORE; c++) begin : g_c
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> (|mbox_pend[c*NMBOX +: NMBOX])); // R7
    AST_FIQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      fiq[c] |-> (|mbox_pend[c*NMBOX +: NMBOX])); // R7
  end

  for (genvar i = 0; i < NCORE*NMBOX; i++) begin : g_b
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_pend[i] && clr_word[i*DW +: DW] == '0) |=> mbox_pend[i]); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_word[i*DW +: DW]) |=> mbox_pend[i]); // R8
    AST_EMPTY_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!mbox_pend[i] && set_word[i*DW +: DW] == '0) |=> !mbox_pend[i]); // R5
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !req_write[p]) |=> rsp_valid[p]); // R3
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[p] && !req_write[p]) |=> !rsp_valid[p]); // R3
  end
endmodule

bind mbx_doorbell mbx_doorbell_chk #(
  .NCORE(NCORE), .NMBOX(NMBOX), .DW(DW), .NPORT(NPORT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .mbox_pend (mbox_pend),
  .irq       (irq),
  .fiq       (fiq),
  .set_word  (set_word),
  .clr_word  (clr_word)
);

// File: tb/sim_mbx_doorbell.sv
`timescale 1ns/1ps
module sim_mbx_doorbell;
  localparam int NCORE = 4;
  localparam int NMBOX = 4;
  localparam int DW    = 32;
  localparam int AW    = 8;
  localparam int NPORT = 2;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NPORT-1:0]       req_valid = '0;
  logic [NPORT-1:0]       req_ready;
  logic [NPORT-1:0]       req_write = '0;
  logic [NPORT*AW-1:0]    req_addr = '0;
  logic [NPORT*DW-1:0]    req_wdata = '0;
  logic [NPORT-1:0]       rsp_valid;
  logic [NPORT*DW-1:0]    rsp_rdata;
  logic [NCORE*NMBOX-1:0] mbox_pend;
  logic [NCORE-1:0]       irq;
  logic [NCORE-1:0]       fiq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbx_doorbell #(.NCORE(NCORE), .NMBOX(NMBOX), .DW(DW), .AW(AW), .NPORT(NPORT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mbox_pend(mbox_pend),
    .irq(irq), .fiq(fiq)
  );

  function automatic logic [7:0] set_a(int c, int m); return 8'(32'h80 + 16*c + 4*m); endfunction
  function automatic logic [7:0] clr_a(int c, int m); return 8'(32'hC0 + 16*c + 4*m); endfunction
  function automatic logic [7:0] cfg_a(int c);        return 8'(32'h50 + 4*c); endfunction
  function automatic logic [7:0] pnd_a(int c);        return 8'(32'h60 + 4*c); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(int p, bit w, logic [7:0] a, logic [31:0] d);
    req_valid[p]           = 1'b1;
    req_write[p]           = w;
    req_addr[p*AW +: AW]   = a;
    req_wdata[p*DW +: DW]  = d;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    req_write = '0;
  endtask

  task automatic wr(int p, logic [7:0] a, logic [31:0] d);
    put(p, 1'b1, a, d);
    step();
  endtask

  task automatic rd(int p, logic [7:0] a, output logic [31:0] d);
    put(p, 1'b0, a, '0);
    step();
    chk("R3 rsp_valid after read", 32'(rsp_valid[p]), 32'd1);
    d = rsp_rdata[p*DW +: DW];
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 mbox_pend after reset", 32'(mbox_pend), 32'd0);
    chk("R9 irq after reset", 32'(irq), 32'd0);
    chk("R9 fiq after reset", 32'(fiq), 32'd0);
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R3 req_ready high", 32'(req_ready), 32'd3);
    rd(0, cfg_a(3), d);
    chk("R9 cfg reset", d, 32'd0);
    rd(1, clr_a(3, 2), d);
    chk("R9 mailbox reset", d, 32'd0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    wr(0, set_a(2, 1), 32'h0000_00A5);
    chk("R3 no rsp after write", 32'(rsp_valid[0]), 32'd0);
    rd(1, clr_a(2, 1), d);
    chk("R1 set posts bits", d, 32'h0000_00A5);
    rd(1, clr_a(2, 1), d);
    chk("R3 read leaves contents", d, 32'h0000_00A5);
    rd(0, set_a(2, 1), d);
    chk("R3 set window reads contents", d, 32'h0000_00A5);
    wr(1, set_a(2, 1), 32'h0000_0F00);
    rd(0, clr_a(2, 1), d);
    chk("R1 set keeps other bits", d, 32'h0000_0FA5);
    chk("R5 mbox_pend bit 9", 32'(mbox_pend), 32'h0000_0200);
    rd(0, pnd_a(2), d);
    chk("R5 pending word bit 5", d, 32'h0000_0020);
    wr(0, clr_a(2, 1), 32'h0000_0005);
    rd(0, clr_a(2, 1), d);
    chk("R2 clear exact bits", d, 32'h0000_0FA0);
    wr(0, clr_a(2, 1), 32'h0000_0F00);
    chk("R6 pending after partial clear", 32'(mbox_pend), 32'h0000_0200);
    wr(0, clr_a(2, 1), 32'h0000_00A0);
    chk("R6 pending drops when empty", 32'(mbox_pend), 32'd0);
    rd(1, pnd_a(2), d);
    chk("R5 pending word empty", d, 32'd0);
  endtask

  task automatic t_cfg_irq();
    logic [31:0] d;
    // core1: bit1 = IRQ enable for mailbox 1, bit4 = FIQ enable for mailbox 0
    wr(0, cfg_a(1), 32'hFFFF_FF12);
    rd(1, cfg_a(1), d);
    chk("R4 cfg readback", d, 32'h0000_0012);
    wr(1, set_a(1, 0), 32'h8000_0000);
    chk("R7 fiq from mailbox 0", 32'(fiq), 32'h2);
    chk("R7 no irq from mailbox 0", 32'(irq), 32'h0);
    wr(1, set_a(1, 1), 32'h0000_0001);
    chk("R7 irq from mailbox 1", 32'(irq), 32'h2);
    wr(1, set_a(1, 2), 32'h0000_0001);
    wr(0, clr_a(1, 0), 32'hFFFF_FFFF);
    wr(0, clr_a(1, 1), 32'hFFFF_FFFF);
    chk("R7 disabled mailbox 2 gives no irq", 32'(irq), 32'h0);
    chk("R7 fiq drops", 32'(fiq), 32'h0);
    chk("R5 only mailbox 2 pending", 32'(mbox_pend), 32'h0000_0040);
    wr(0, clr_a(1, 2), 32'h0000_0001);
    wr(0, cfg_a(1), 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(0, set_a(3, 3), 32'h0000_0F0F);
    put(0, 1'b1, set_a(3, 3), 32'h0000_00F0);
    put(1, 1'b1, clr_a(3, 3), 32'h0000_0FF0);
    step();
    rd(0, clr_a(3, 3), d);
    chk("R8 set wins over clear", d, 32'h0000_00FF);
    put(0, 1'b1, set_a(3, 3), 32'h0001_0000);
    put(1, 1'b1, set_a(3, 3), 32'h0010_0000);
    step();
    rd(1, clr_a(3, 3), d);
    chk("R8 concurrent sets OR", d, 32'h0011_00FF);
    wr(1, clr_a(3, 3), 32'hFFFF_FFFF);
    chk("R2 full clear", 32'(mbox_pend), 32'd0);
  endtask

  task automatic t_cfg_conflict();
    logic [31:0] d;
    put(0, 1'b1, cfg_a(0), 32'h0000_0001);
    put(1, 1'b1, cfg_a(0), 32'h0000_0080);
    step();
    rd(0, cfg_a(0), d);
    chk("R11 highest port wins", d, 32'h0000_0080);
    wr(0, cfg_a(0), 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(0, 8'h81, 32'hFFFF_FFFF);
    wr(1, 8'h70, 32'hFFFF_FFFF);
    wr(0, 8'h00, 32'hFFFF_FFFF);
    chk("R10 stray writes post nothing", 32'(mbox_pend), 32'd0);
    rd(0, clr_a(0, 0), d);
    chk("R10 mailbox untouched", d, 32'd0);
    rd(1, 8'h00, d);
    chk("R10 unmapped read zero", d, 32'd0);
    rd(1, 8'h52, d);
    chk("R10 misaligned read zero", d, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_cfg_irq();
    t_race();
    t_cfg_conflict();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule